// File: doc/BRIEF.md
# Disk command block validator

This block receives a five-byte disk command parameter block and decides, before any drive activity starts, whether the command may be executed. The bytes arrive one per clock over a valid/ready handshake, in this fixed order: channel word, instruction word, record count, track, sector. Once the fifth byte has been stored, the block evaluates the whole block combinationally in the next cycle. In that cycle it raises a one-cycle `done` strobe and presents the following results together: the operation code, a drive control byte, the masked start sector, the record count, and either an accept pulse or a coded error.

The channel word is checked first. A faulty channel word blocks every address check. The address checks depend on the operation. Operations that move the head or transfer data have their track and sector range-checked. Operations that never use the address are passed through without those checks. Before any check, the sector byte is stripped of two legacy drive-select bits. A final check rejects any transfer whose last sector would run past the end of the track.

Top module: `cmd_block_validator`

## Requirements
- R1: A byte is taken on each rising edge where `in_valid` and `in_ready` are both high. The bytes land in the order channel, instruction, record count, track, sector. `done` is high for exactly one cycle, in the cycle after the fifth byte is taken. `in_ready` is low during that cycle and high in the cycle after it. `rec_count` equals the third byte.
- R2: If any of channel word bits 5:0 is set, `err_code` is 1 (channel error) and `accept` stays low, whatever the address fields hold. Channel word bits 7:6 have no effect.
- R3: `op_code` equals instruction word bits 2:0. The codes are 0 no-op, 1 seek, 2 format, 3 recalibrate, 4 read, 5 verify, 6 write, 7 write with deleted-data mark.
- R4: For op codes 0, 2 and 3 with a clean channel word, the block accepts whatever the track, sector and count hold.
- R5: For op code 1 and op codes 4 to 7, a track byte above 0x4C gives `err_code` 2 (address error). A track of 0x4C is allowed.
- R6: `start_sector` equals the sector byte ANDed with 0x9F. For the checked operations, a masked value of zero is an address error.
- R7: For the checked operations, a masked sector above 0x1A is an address error.
- R8: For the checked operations, if the masked sector plus the record count, summed at full width without wrap, is above 0x1B, the result is an address error.
- R9: `drive_ctl` is 0xB2 when instruction word bits 5:4 equal 3 and 0xB1 otherwise. Bit 7 is auto-wait, bit 5 is motor on, bit 4 is single density, and bits 3:0 are a one-hot drive select.
- R10: `accept` is high only together with `done` and only when `err_code` is 0. `err_code` reads 0 while `done` is low.
- R11: While `rst_n` is low, `in_ready`, `done` and `accept` are low. A reset discards any partly loaded block, so the next block starts again at the channel word.
- R12: A cycle with `in_valid` low takes no byte and does not advance the load sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Parameter byte present |
| in_byte | input | 8 | Parameter byte |
| in_ready | output | 1 | Block can take a byte |
| done | output | 1 | One-cycle strobe: results valid |
| accept | output | 1 | Block accepted (with done) |
| err_code | output | 2 | 0 none, 1 channel error, 2 address error |
| op_code | output | 3 | Decoded operation |
| drive_ctl | output | 8 | Drive control byte |
| start_sector | output | 8 | Sector byte masked with 0x9F |
| rec_count | output | 8 | Record count byte |

## Verification
A channel fault and one or more address faults can be present in the same block and are judged in the same cycle. Only one code can be reported. The table therefore includes blocks with a bad channel word together with an out-of-range track and a zero sector. Each of these must come back with the channel code, never the address code. A second same-cycle case is the end-of-track rule: a start sector at the limit meets a record count that pushes the sum past it. Both 0x1A with a count of 1 (accepted) and 0x1A with a count of 2 or 0xFF (rejected) are checked, and the last of these confirms that the sum does not wrap.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FIELD_CNT = 5;
  localparam int unsigned IDX_W     = $clog2(FIELD_CNT);

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CHAN = 2'd1,
    ERR_ADDR = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    OP_NOP, OP_SEEK, OP_FORMAT, OP_RECAL,
    OP_READ, OP_VERIFY, OP_WRITE, OP_WRDEL
  } op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] chan;
    logic [BYTE_W-1:0] instr;
    logic [BYTE_W-1:0] count;
    logic [BYTE_W-1:0] track;
    logic [BYTE_W-1:0] sector;
  } blk_t;
endpackage

// File: rtl/dcv_loader.sv
module dcv_loader
  import dcv_pkg::*;
#(
  parameter int unsigned NB = FIELD_CNT,
  parameter int unsigned W  = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_byte,
  output logic          in_ready,
  output logic          full,
  output logic [NB*W-1:0] bytes_flat
);
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NB-1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_d;
  logic          take;

  assign in_ready = rst_n & ~full;
  assign take     = in_valid & in_ready;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = 1'b0;
    if (take) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      full  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      full  <= full_d;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic         wr_en;
    logic [W-1:0] q;
    assign wr_en = take & (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= in_byte;
    end
    assign bytes_flat[i*W +: W] = q;
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_full_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !full);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));
endmodule

// File: rtl/dcv_checker.sv
module dcv_checker
  import dcv_pkg::*;
#(
  parameter int unsigned     W           = BYTE_W,
  parameter logic [W-1:0]    CHAN_MASK   = 8'h3F,
  parameter logic [W-1:0]    SECTOR_MASK = 8'h9F,
  parameter logic [W-1:0]    MAX_TRACK   = 8'h4C,
  parameter logic [W-1:0]    MAX_SECTOR  = 8'h1A
) (
  input  logic [W-1:0] chan,
  input  logic [2:0]   op_field,
  input  logic [W-1:0] count,
  input  logic [W-1:0] track,
  input  logic [W-1:0] sector,
  output err_e         err,
  output op_e          op,
  output logic [W-1:0] msec
);
  localparam logic [W:0] SPAN_LIMIT = {1'b0, MAX_SECTOR} + 1'b1;

  logic       chan_bad, need_addr, trk_bad, sec_bad, span_bad;
  logic [W:0] span;

  always_comb begin
    op        = op_e'(op_field);
    chan_bad  = |(chan & CHAN_MASK);
    need_addr = (op == OP_SEEK) | op_field[2];
    msec      = sector & SECTOR_MASK;
    trk_bad   = track > MAX_TRACK;
    sec_bad   = (msec == '0) | (msec > MAX_SECTOR);
    span      = {1'b0, msec} + {1'b0, count};
    span_bad  = span > SPAN_LIMIT;
    if (chan_bad)                                     err = ERR_CHAN;
    else if (need_addr & (trk_bad | sec_bad | span_bad)) err = ERR_ADDR;
    else                                              err = ERR_NONE;
  end
endmodule

// File: rtl/dcv_drive_sel.sv
module dcv_drive_sel #(
  parameter int unsigned DRV_BITS = 4
) (
  input  logic [1:0] drv_field,
  output logic [7:0] drive_ctl
);
  localparam int unsigned SEL_W   = $clog2(DRV_BITS);
  localparam logic        AUTO_WT = 1'b1;
  localparam logic        MOTOR   = 1'b1;
  localparam logic        SINGLE  = 1'b1;

  logic [SEL_W-1:0]    idx;
  logic [DRV_BITS-1:0] sel;

  assign idx = (drv_field == 2'b11) ? SEL_W'(1) : SEL_W'(0);

  for (genvar i = 0; i < DRV_BITS; i++) begin : g_sel
    assign sel[i] = (idx == SEL_W'(i));
  end

  assign drive_ctl = {AUTO_WT, 1'b0, MOTOR, SINGLE, sel};
endmodule

// File: rtl/cmd_block_validator.sv
module cmd_block_validator
  import dcv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        done,
  output logic        accept,
  output logic [1:0]  err_code,
  output logic [2:0]  op_code,
  output logic [7:0]  drive_ctl,
  output logic [7:0]  start_sector,
  output logic [7:0]  rec_count
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [FIELD_CNT*BYTE_W-1:0] flat;
  logic                        full;
  blk_t                        blk;
  err_e                        err;
  op_e                         op;
  logic [BYTE_W-1:0]           msec;
  logic                        unused_instr_bits;

  dcv_loader #(.NB(FIELD_CNT), .W(BYTE_W)) u_load (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .full(full), .bytes_flat(flat)
  );

  assign blk.chan   = flat[0*BYTE_W +: BYTE_W];
  assign blk.instr  = flat[1*BYTE_W +: BYTE_W];
  assign blk.count  = flat[2*BYTE_W +: BYTE_W];
  assign blk.track  = flat[3*BYTE_W +: BYTE_W];
  assign blk.sector = flat[4*BYTE_W +: BYTE_W];
  assign unused_instr_bits = ^{blk.instr[7:6], blk.instr[3]};

  dcv_checker #(.W(BYTE_W)) u_chk (
    .chan(blk.chan), .op_field(blk.instr[2:0]), .count(blk.count),
    .track(blk.track), .sector(blk.sector),
    .err(err), .op(op), .msec(msec)
  );

  dcv_drive_sel #(.DRV_BITS(4)) u_drv (
    .drv_field(blk.instr[5:4]), .drive_ctl(drive_ctl)
  );

  assign done         = full;
  assign err_code     = full ? err : ERR_NONE;
  assign accept       = full & (err == ERR_NONE);
  assign op_code      = op;
  assign start_sector = msec;
  assign rec_count    = blk.count;

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_ready_after_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> in_ready);
  p_chan_first_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && (blk.chan[5:0] != 6'd0)) |-> (err_code == 2'd1 && !accept));
  p_skip_ops_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && blk.chan[5:0] == 6'd0 &&
     (blk.instr[2:0] == 3'd0 || blk.instr[2:0] == 3'd2 || blk.instr[2:0] == 3'd3))
    |-> accept);
  p_sector_mask_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (start_sector[6:5] == 2'b00));
  p_drive_onehot_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> ($countones(drive_ctl[3:0]) == 1 && drive_ctl[7:4] == 4'hB));
  p_accept_clean_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |-> (done && err_code == 2'd0));
endmodule

// File: tb/tb_cmd_block_validator.sv
module tb_cmd_block_validator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready, done, accept;
  logic [1:0] err_code;
  logic [2:0] op_code;
  logic [7:0] drive_ctl, start_sector, rec_count;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmd_block_validator dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .accept(accept), .err_code(err_code),
    .op_code(op_code), .drive_ctl(drive_ctl), .start_sector(start_sector),
    .rec_count(rec_count)
  );

  // chan, instr, count, track, sector | err, drive, masked sector
  localparam int NV = 17;
  localparam logic [57:0] VEC [NV] = '{
    {8'h00,8'h04,8'h01,8'h00,8'h01, 2'd0,8'hB1,8'h01}, // R3 read, first drive
    {8'h00,8'h34,8'h01,8'h4C,8'h1A, 2'd0,8'hB2,8'h1A}, // R5 R8 limits, R9 B2
    {8'h00,8'h04,8'h01,8'h4D,8'h01, 2'd2,8'hB1,8'h01}, // R5 track 0x4D
    {8'h00,8'h06,8'h01,8'h10,8'h00, 2'd2,8'hB1,8'h00}, // R6 zero sector
    {8'h00,8'h06,8'h01,8'h10,8'h60, 2'd2,8'hB1,8'h00}, // R6 masked to zero
    {8'h00,8'h05,8'h01,8'h10,8'h1B, 2'd2,8'hB1,8'h1B}, // R7 sector 0x1B
    {8'h00,8'h04,8'h02,8'h10,8'h1A, 2'd2,8'hB1,8'h1A}, // R8 sum 0x1C
    {8'h00,8'h04,8'hFF,8'h10,8'h1A, 2'd2,8'hB1,8'h1A}, // R8 no wrap
    {8'h01,8'h04,8'h01,8'h00,8'h01, 2'd1,8'hB1,8'h01}, // R2 channel bit 0
    {8'h20,8'h04,8'h01,8'hFF,8'h00, 2'd1,8'hB1,8'h00}, // R2 channel beats address
    {8'hC0,8'h04,8'h01,8'h00,8'h01, 2'd0,8'hB1,8'h01}, // R2 bits 7:6 ignored
    {8'h00,8'h00,8'h00,8'hFF,8'h00, 2'd0,8'hB1,8'h00}, // R4 no-op unchecked
    {8'h00,8'h02,8'hFF,8'hFF,8'hFF, 2'd0,8'hB1,8'h9F}, // R4 format unchecked
    {8'h00,8'h13,8'h00,8'hFF,8'hFF, 2'd0,8'hB1,8'h9F}, // R4 recal, R9 field 1
    {8'h00,8'h01,8'h05,8'h4D,8'h05, 2'd2,8'hB1,8'h05}, // R5 seek checked
    {8'h00,8'h27,8'h01,8'h05,8'hE1, 2'd2,8'hB1,8'h81}, // R7 masked 0x81
    {8'h00,8'h37,8'h00,8'h4C,8'h7A, 2'd0,8'hB2,8'h1A}  // R6 mask keeps 0x1A
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic send(input logic [39:0] blk);
    for (int k = 0; k < 5; k++) put(blk[39-8*k -: 8]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic judge(input logic [57:0] v);
    chk("R1 done", {15'd0, done}, 16'd1);
    chk("R1 ready low in done", {15'd0, in_ready}, 16'd0);
    chk("R1 rec_count", {8'd0, rec_count}, {8'd0, v[41:34]});
    chk("R3 op_code", {13'd0, op_code}, {13'd0, v[44:42]});
    chk("R2/R5-R8 err_code", {14'd0, err_code}, {14'd0, v[17:16]});
    chk("R10 accept", {15'd0, accept}, {15'd0, (v[17:16] == 2'd0)});
    chk("R9 drive_ctl", {8'd0, drive_ctl}, {8'd0, v[15:8]});
    chk("R6 start_sector", {8'd0, start_sector}, {8'd0, v[7:0]});
    @(negedge clk);
    chk("R1 done one cycle", {15'd0, done}, 16'd0);
    chk("R10 err zero when idle", {14'd0, err_code}, 16'd0);
    chk("R1 ready back", {15'd0, in_ready}, 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ready in reset", {15'd0, in_ready}, 16'd0);
    chk("R11 done in reset", {15'd0, done}, 16'd0);
    chk("R11 accept in reset", {15'd0, accept}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ready after reset", {15'd0, in_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][57:18]);
      judge(VEC[i]);
    end

    // R11 partial block discarded by reset
    put(8'h3F); put(8'h04); put(8'h01);
    @(negedge clk); in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send({8'h00,8'h34,8'h01,8'h4C,8'h1A});
    judge({8'h00,8'h34,8'h01,8'h4C,8'h1A, 2'd0,8'hB2,8'h1A}); // R11

    // R12 idle cycles between bytes do not advance
    put(8'h00); @(negedge clk); in_valid = 1'b0; in_byte = 8'hFF;
    repeat (2) @(negedge clk);
    put(8'h06); @(negedge clk); in_valid = 1'b0;
    put(8'h03); put(8'h20); @(negedge clk); in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R12 no done after four bytes", {15'd0, done}, 16'd0);
    put(8'h05);
    @(negedge clk); in_valid = 1'b0;
    judge({8'h00,8'h06,8'h03,8'h20,8'h05, 2'd0,8'hB1,8'h05}); // R12

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule